// File: doc/BRIEF.md
# Dual-Register Edge Capture Unit

This block timestamps transitions on an external signal. A free-running up-counter advances once per clock while the block is enabled. When the chosen transition appears on the selected capture pin, the counter value of that moment is stored in one of two result registers, A or B. A two-bit edge field chooses which transitions count: rising, falling, both, or none. A two-bit routing field chooses where each stored value goes. This lets one register collect rising-edge times and the other collect falling-edge times, which is enough to measure pulse width and period in hardware.

The capture pin is picked from two inputs by a source-select bit and passes through a two-stage synchronizer before edges are detected. Each register write raises a one-cycle strobe that names the register written. The results are level outputs that a newer capture overwrites. They carry no valid/ready handshake because no data stream leaves the block, so no back-pressure applies. A reader that misses a strobe sees only the most recent value.

Top module: `edge_capture_unit`

## Requirements
- R1: While `en` is low the counter is held at 0. Each clock with `en` high adds one, and the counter wraps from 16'hFFFF to 0.
- R2: Suppose a selected pin transition is stable before clock edge k. Then the capture happens at edge k+2 and stores the counter value held just after edge k+1. The write strobe is high for exactly the cycle that follows edge k+2.
- R3: Edge field `edge_mode` selects the trigger. 2'b00 captures on rising edges only, 2'b01 on falling edges only, 2'b10 on both, and 2'b11 captures nothing.
- R4: When `route_mode` is 2'b00, every capture writes register A.
- R5: When `route_mode` is 2'b01, 2'b10 or 2'b11, a rising-edge capture writes register B and a falling-edge capture writes register A.
- R6: `src_sel` = 0 takes the trigger from `cap_in0` and `src_sel` = 1 from `cap_in1`. Transitions on the unselected pin cause no capture.
- R7: While `en` is low, no capture occurs, whatever the pins do.
- R8: After reset both registers read 0 and both strobes are low. At most one strobe is high in any cycle. A register changes value only in the cycle its strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable for counter and capture |
| cap_in0 | input | 1 | Capture pin 0 (asynchronous) |
| cap_in1 | input | 1 | Capture pin 1 (asynchronous) |
| src_sel | input | 1 | Pin select: 0 = cap_in0, 1 = cap_in1 |
| edge_mode | input | 2 | Trigger edge: 00 rise, 01 fall, 10 both, 11 off |
| route_mode | input | 2 | Destination routing: 00 all to A, else rise to B and fall to A |
| reg_a | output | 16 | Capture register A |
| reg_b | output | 16 | Capture register B |
| wr_a | output | 1 | One-cycle strobe: register A was written |
| wr_b | output | 1 | One-cycle strobe: register B was written |

## Verification
Every stored value is compared with an independent counter model at the exact cycle R2 predicts. A counter that is off by one, fails to wrap, or fails to clear shows up as a wrong value at the first capture after the fault. A synchronizer with the wrong depth shifts every captured value by one count at the first capture. Wrong edge decoding or routing shows as a strobe on the wrong register, or as an unexpected or missing strobe, within three cycles of the pin transition. Registers are also checked to hold their values between strobes.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_sel_e;

  localparam logic [1:0] ROUTE_ALL_A = 2'b00;
endpackage

// File: rtl/ecu_sync_edge.sv
module ecu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R3
endmodule

// File: rtl/ecu_counter.sv
module ecu_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!en) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R1
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt == W'($past(cnt) + 1))); // R1
endmodule

// File: rtl/ecu_route.sv
module ecu_route
  import ecu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rise,
  input  logic         fall,
  input  logic [1:0]   edge_mode,
  input  logic [1:0]   route_mode,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic         wr_a,
  output logic         wr_b
);
  logic take_rise, take_fall, to_a, to_b, split;

  always_comb begin
    take_rise = en && rise &&
                (edge_mode == EDGE_RISE || edge_mode == EDGE_BOTH);
    take_fall = en && fall &&
                (edge_mode == EDGE_FALL || edge_mode == EDGE_BOTH);
    split     = (route_mode != ROUTE_ALL_A);
    to_b      = take_rise && split;
    to_a      = take_fall || (take_rise && !split);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
      wr_a  <= 1'b0;
      wr_b  <= 1'b0;
    end else begin
      wr_a <= to_a;
      wr_b <= to_b;
      if (to_a) reg_a <= cnt;
      if (to_b) reg_b <= cnt;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_a, wr_b})); // R8
  AST_A_CHANGES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_a) |-> wr_a); // R8
  AST_B_CHANGES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_b) |-> wr_b); // R8
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == EDGE_OFF) |=> !(wr_a || wr_b)); // R3
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(wr_a || wr_b)); // R7
  AST_DEFAULT_ROUTE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mode == ROUTE_ALL_A) |=> !wr_b); // R4
  AST_SPLIT_FALL_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fall && route_mode != ROUTE_ALL_A &&
     (edge_mode == EDGE_FALL || edge_mode == EDGE_BOTH)) |=> wr_a); // R5
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int CW          = CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cap_in0,
  input  logic          cap_in1,
  input  logic          src_sel,
  input  logic [1:0]    edge_mode,
  input  logic [1:0]    route_mode,
  output logic [CW-1:0] reg_a,
  output logic [CW-1:0] reg_b,
  output logic          wr_a,
  output logic          wr_b
);
  logic          pin;
  logic          rise, fall;
  logic [CW-1:0] cnt;

  assign pin = src_sel ? cap_in1 : cap_in0;

  ecu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin), .rise(rise), .fall(fall)
  );

  ecu_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt)
  );

  ecu_route #(.W(CW)) u_route (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(rise), .fall(fall),
    .edge_mode(edge_mode), .route_mode(route_mode), .cnt(cnt),
    .reg_a(reg_a), .reg_b(reg_b), .wr_a(wr_a), .wr_b(wr_b)
  );
endmodule

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cap_in0 = 1'b0;
  logic cap_in1 = 1'b0;
  logic src_sel = 1'b0;
  logic [1:0] edge_mode = 2'b11;
  logic [1:0] route_mode = 2'b00;
  logic [W-1:0] reg_a, reg_b;
  logic wr_a, wr_b;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model_cnt = '0;
  logic [W-1:0] last_a = '0;
  logic [W-1:0] last_b = '0;
  logic [W:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cap_in0(cap_in0), .cap_in1(cap_in1),
    .src_sel(src_sel), .edge_mode(edge_mode), .route_mode(route_mode),
    .reg_a(reg_a), .reg_b(reg_b), .wr_a(wr_a), .wr_b(wr_b)
  );

  // Counter model from R1
  always @(posedge clk) begin
    if (!rst_n || !en) model_cnt <= '0;
    else               model_cnt <= model_cnt + 1'b1;
  end

  // Monitor: scoreboard pop and compare (R2, R4, R5, R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_a && wr_b) begin
        checks++; failures++;
        $display("FAIL R8 both strobes high: act=2'b11 exp=one-hot");
      end
      if (wr_a || wr_b) begin
        logic [W:0] it;
        logic       dest_b;
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R3/R6/R7 unexpected write: act wr_a=%0d wr_b=%0d a=%0d b=%0d exp=none",
                   wr_a, wr_b, reg_a, reg_b);
        end else begin
          it = exp_q.pop_front();
          dest_b = it[W];
          if (dest_b ? !wr_b : !wr_a) begin
            failures++;
            $display("FAIL R4/R5 destination: act wr_a=%0d wr_b=%0d exp dest_b=%0d",
                     wr_a, wr_b, dest_b);
          end else if ((dest_b ? reg_b : reg_a) != it[W-1:0]) begin
            failures++;
            $display("FAIL R1/R2 captured value: act=%0d exp=%0d",
                     dest_b ? reg_b : reg_a, it[W-1:0]);
          end
        end
        if (wr_a) last_a = reg_a;
        if (wr_b) last_b = reg_b;
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // Driver: drive a pin level, push the expected item if a capture is due
  task automatic drive(input bit pin1, input bit level, input bit expect_cap, input bit dest_b);
    @(negedge clk);
    if (pin1) cap_in1 = level; else cap_in0 = level;
    @(posedge clk);
    @(posedge clk);
    #1;
    if (expect_cap) exp_q.push_back({dest_b, model_cnt});
    idle(4);
    #1;
    check("R8 hold A", reg_a, last_a);
    check("R8 hold B", reg_b, last_b);
  endtask

  task automatic set_modes(input logic [1:0] e, input logic [1:0] r);
    @(negedge clk);
    edge_mode = e;
    route_mode = r;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    #1;
    check("R8 reset reg_a", reg_a, '0);
    check("R8 reset reg_b", reg_b, '0);
    check("R8 reset strobes", {15'd0, wr_a | wr_b}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    idle(5);

    // R3 R4 rising only, all to A
    set_modes(2'b00, 2'b00);
    drive(0, 1, 1, 0);
    drive(0, 0, 0, 0);
    // R3 falling only
    set_modes(2'b01, 2'b00);
    drive(0, 1, 0, 0);
    drive(0, 0, 1, 0);
    // R3 both edges, R4 all to A
    set_modes(2'b10, 2'b00);
    drive(0, 1, 1, 0);
    drive(0, 0, 1, 0);
    // R5 rising to B
    set_modes(2'b00, 2'b01);
    drive(0, 1, 1, 1);
    drive(0, 0, 0, 0);
    // R5 falling to A
    set_modes(2'b01, 2'b10);
    drive(0, 1, 0, 0);
    drive(0, 0, 1, 0);
    // R5 both edges split
    set_modes(2'b10, 2'b11);
    drive(0, 1, 1, 1);
    drive(0, 0, 1, 0);
    // R3 off
    set_modes(2'b11, 2'b01);
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    // R6 source select
    set_modes(2'b10, 2'b01);
    @(negedge clk); src_sel = 1'b1;
    idle(4);
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    drive(1, 1, 1, 1);
    drive(1, 0, 1, 0);
    @(negedge clk); src_sel = 1'b0;
    idle(4);
    // R7 disabled
    @(negedge clk); en = 1'b0;
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    // R1 restart from zero after disable, then wrap
    @(negedge clk); en = 1'b1;
    drive(0, 1, 1, 1);
    drive(0, 0, 1, 0);
    idle(65530);
    drive(0, 1, 1, 1);
    drive(0, 0, 1, 0);

    idle(5);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 missing writes: act pending=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule